// File: doc/BRIEF.md
# Circular Sector Buffer Pointer Manager

This block manages the addresses of a dual-ported word buffer that sits between a host transfer path and a local processor. It keeps three pointers: a host pointer that walks the buffer as host words move, a stop pointer that marks the last word of a host burst, and a disk pointer that the processor uses through a data access port. Every pointer wraps at a power-of-two buffer size chosen by a 3-bit code. The buffer itself is an external synchronous RAM with one cycle of read latency. The block drives that RAM's single port and arbitrates it between the two sides.

The processor programs the size, the pointers, the host transfer direction and the completion modes through a small register port, then sets the run bit. The host side moves one word per accepted strobe while the host request output is high. The burst ends on the word whose address equals the stop pointer. At that point the block clears run and sets the done bit. If the matching mode bits are set, it also raises a host busy flag and a host interrupt.

Top module: `sector_ring_ctrl`

## Requirements
- R1: After reset, the host pointer and disk pointer read 0000h, the stop pointer reads 00FFh, and the config and control registers read 0. The outputs `host_req`, `host_busy`, `host_irq` and `ram_en` are low.
- R2: Config bits [2:0] select the buffer size: 000 and 001 give 32K words, 010 gives 16K, 011 gives 8K, 100 gives 4K, 101 gives 2K, 110 gives 1K and 111 gives 512 words. A pointer at size-1 advances to 0.
- R3: Control bit [2] selects the direction. With 1, each accepted host strobe writes `host_wdata` to the RAM at the host pointer. With 0, it reads the RAM, and `host_rdata` and `host_rvalid` are valid one cycle after the strobe.
- R4: Each accepted host word uses the host pointer as the RAM address, and the pointer then advances by one modulo the buffer size.
- R5: The host word whose address equals the stop pointer ends the burst. Control bit [0] (run) clears, control bit [1] (done) sets, and `host_req` drops. Later strobes do not touch the RAM or the pointer. Writing run=1 clears done.
- R6: When control bit [4] is set, completion sets the busy flag (control bit [6], output `host_busy`). Otherwise the flag stays clear. The processor clears the flag by writing 0 to that bit.
- R7: When control bit [3] is set, completion sets the interrupt flag (control bit [7], output `host_irq`). Otherwise the flag stays clear. The processor clears the flag by writing 0 to that bit.
- R8: Register 5 is the data port. It reads or writes the RAM at the disk pointer. When config bit [3] is set, the disk pointer advances modulo the size after each access; otherwise it holds. Every register read returns its data on `cpu_rdata` one cycle after it is accepted.
- R9: If a host strobe and a data-port access fall in the same cycle, the host uses the RAM and `cpu_ready` is low. The processor access completes in the next cycle in which the RAM is free.
- R10: When control bit [5] (RAM off) is set, `ram_en` stays low and `host_req` is low. Host strobes are ignored. Data-port writes are dropped, data-port reads return 0, and the disk pointer holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_sel | input | 1 | Processor register access request |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 3 | Register: 0 config, 1 host ptr, 2 stop ptr, 3 disk ptr, 4 control, 5 data port |
| cpu_wdata | input | DW | Write data |
| cpu_rdata | output | DW | Read data, one cycle after acceptance |
| cpu_ready | output | 1 | Access accepted this cycle |
| host_stb | input | 1 | Host word strobe |
| host_wdata | input | DW | Host word for host-to-buffer transfers |
| host_req | output | 1 | Block accepts host strobes |
| host_rdata | output | DW | Buffer word for buffer-to-host transfers |
| host_rvalid | output | 1 | `host_rdata` valid |
| host_busy | output | 1 | Busy flag |
| host_irq | output | 1 | Completion interrupt flag |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | AW | RAM word address |
| ram_wdata | output | DW | RAM write data |
| ram_rdata | input | DW | RAM read data, one cycle after `ram_en` |

## Verification
Directed bursts that cross the wrap point show whether the mask is applied to both the address and the stop compare. A host pointer preset to size-1 under every size code tells the eight size decodings apart. The mode bits are run in three combinations (none, interrupt only, both), which separates the busy and interrupt paths. A host strobe and a data-port access in the same cycle expose the arbitration. Random bursts, with a random start, length, size and direction, compare written words against a model kept in the bench, and read words against the same model.

// File: rtl/sector_ring_ctrl.sv
`timescale 1ns/1ps
module sector_ring_ctrl #(
  parameter int AW = 15,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cpu_sel,
  input  logic          cpu_wr,
  input  logic [2:0]    cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          cpu_ready,
  input  logic          host_stb,
  input  logic [DW-1:0] host_wdata,
  output logic          host_req,
  output logic [DW-1:0] host_rdata,
  output logic          host_rvalid,
  output logic          host_busy,
  output logic          host_irq,
  output logic          ram_en,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  input  logic [DW-1:0] ram_rdata
);
  localparam logic [AW-1:0] STOP_RST = AW'(8'hFF);

  logic [2:0]    size_code;
  logic          auto_inc;
  logic [AW-1:0] hp, sp, dp;
  logic          run, done, dir, irq_en, busy_en, ram_off, busy_f, irq_f;
  logic          port_rd_q;
  logic [DW-1:0] reg_rd_q;

  logic [2:0]    shift;
  logic [AW-1:0] mask, hp_m, sp_m, dp_m, hp_next, dp_next;
  logic          host_go, hp_hit, cpu_port, cpu_port_go;
  logic [DW-1:0] rd_mux;

  assign shift   = (size_code <= 3'd1) ? 3'd0 : size_code - 3'd1;
  assign mask    = {AW{1'b1}} >> shift;
  assign hp_m    = hp & mask;
  assign sp_m    = sp & mask;
  assign dp_m    = dp & mask;
  assign hp_next = (hp + 1'b1) & mask;
  assign dp_next = (dp + 1'b1) & mask;

  assign host_req    = run && !ram_off;
  assign host_go     = host_req && host_stb;
  assign hp_hit      = hp_m == sp_m;
  assign cpu_port    = cpu_sel && cpu_addr == 3'd5;
  assign cpu_ready   = !(cpu_port && host_go);
  assign cpu_port_go = cpu_port && !host_go && !ram_off;

  assign ram_en    = host_go || cpu_port_go;
  assign ram_we    = host_go ? dir : cpu_wr;
  assign ram_addr  = host_go ? hp_m : dp_m;
  assign ram_wdata = host_go ? host_wdata : cpu_wdata;

  assign host_rdata = ram_rdata;
  assign host_busy  = busy_f;
  assign host_irq   = irq_f;
  assign cpu_rdata  = port_rd_q ? ram_rdata : reg_rd_q;

  always_comb begin
    rd_mux = '0;
    case (cpu_addr)
      3'd0: rd_mux = DW'({auto_inc, size_code});
      3'd1: rd_mux = DW'(hp);
      3'd2: rd_mux = DW'(sp);
      3'd3: rd_mux = DW'(dp);
      3'd4: rd_mux = DW'({irq_f, busy_f, ram_off, busy_en, irq_en, dir, done, run});
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size_code   <= '0;
      auto_inc    <= 1'b0;
      hp          <= '0;
      sp          <= STOP_RST;
      dp          <= '0;
      run         <= 1'b0;
      done        <= 1'b0;
      dir         <= 1'b0;
      irq_en      <= 1'b0;
      busy_en     <= 1'b0;
      ram_off     <= 1'b0;
      busy_f      <= 1'b0;
      irq_f       <= 1'b0;
      host_rvalid <= 1'b0;
      port_rd_q   <= 1'b0;
      reg_rd_q    <= '0;
    end else begin
      host_rvalid <= host_go && !dir;
      port_rd_q   <= cpu_port_go && !cpu_wr;
      if (cpu_sel && !cpu_wr && cpu_ready) reg_rd_q <= rd_mux;

      if (host_go) begin
        hp <= hp_next;
        if (hp_hit) begin
          run  <= 1'b0;
          done <= 1'b1;
          if (busy_en) busy_f <= 1'b1;
          if (irq_en)  irq_f  <= 1'b1;
        end
      end
      if (cpu_port_go && auto_inc) dp <= dp_next;

      if (cpu_sel && cpu_wr) begin
        case (cpu_addr)
          3'd0: begin size_code <= cpu_wdata[2:0]; auto_inc <= cpu_wdata[3]; end
          3'd1: hp <= cpu_wdata[AW-1:0];
          3'd2: sp <= cpu_wdata[AW-1:0];
          3'd3: dp <= cpu_wdata[AW-1:0];
          3'd4: begin
            run     <= cpu_wdata[0];
            if (cpu_wdata[0]) done <= 1'b0;
            dir     <= cpu_wdata[2];
            irq_en  <= cpu_wdata[3];
            busy_en <= cpu_wdata[4];
            ram_off <= cpu_wdata[5];
            busy_f  <= cpu_wdata[6];
            irq_f   <= cpu_wdata[7];
          end
          default: ;
        endcase
      end
    end
  end

  // R3
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_go && !dir) |=> host_rvalid);

  // R4
  hp_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_go && !(cpu_sel && cpu_wr && cpu_addr == 3'd1)) |=> hp == $past(hp_next));

  // R5
  burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_go && hp_hit && !(cpu_sel && cpu_wr && cpu_addr == 3'd4)) |=> (done && !host_req));

  // R5
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> !run);

  // R6
  busy_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && busy_en) |-> host_busy);

  // R9
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_port && host_go) |-> (!cpu_ready && ram_addr == hp_m));
endmodule

// File: tb/test_sector_ring_ctrl.sv
`timescale 1ns/1ps
module test_sector_ring_ctrl;
  localparam int AW = 15;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_sel = 1'b0, cpu_wr = 1'b0;
  logic [2:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0, cpu_rdata;
  logic cpu_ready;
  logic host_stb = 1'b0;
  logic [DW-1:0] host_wdata = '0, host_rdata;
  logic host_req, host_rvalid, host_busy, host_irq;
  logic ram_en, ram_we;
  logic [AW-1:0] ram_addr;
  logic [DW-1:0] ram_wdata;
  logic [DW-1:0] ram_rdata = '0;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [DW-1:0] mem [2048];
  logic [DW-1:0] exp_mem [2048];

  always #2 clk = ~clk;

  sector_ring_ctrl #(.AW(AW), .DW(DW)) i_sector_ring_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cpu_sel(cpu_sel), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .host_stb(host_stb), .host_wdata(host_wdata), .host_req(host_req),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid), .host_busy(host_busy), .host_irq(host_irq),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata));

  always @(posedge clk) if (ram_en) begin
    if (ram_we) mem[ram_addr[10:0]] <= ram_wdata;
    ram_rdata <= mem[ram_addr[10:0]];
  end

  function automatic int size_of(input int code);
    return (code <= 1) ? 32768 : (32768 >> (code - 1));
  endfunction

  task automatic check(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic wr_reg(input int a, input int d);
    cpu_sel = 1; cpu_wr = 1; cpu_addr = 3'(a); cpu_wdata = DW'(d);
    @(negedge clk);
    cpu_sel = 0; cpu_wr = 0;
  endtask

  task automatic rd_reg(input int a, output int d);
    cpu_sel = 1; cpu_wr = 0; cpu_addr = 3'(a);
    @(negedge clk);
    cpu_sel = 0;
    d = int'(cpu_rdata);
  endtask

  task automatic host_word(input bit wr, input logic [DW-1:0] d, input int ea, input string req);
    host_stb = 1; host_wdata = d; #1;
    check(ram_en && ram_addr == AW'(ea) && ram_we == wr, {req, " host word address"}, ram_addr, ea);
    @(negedge clk);
    host_stb = 0;
    if (wr) exp_mem[ea % 2048] = d;
    else begin
      check(host_rvalid, {req, " read valid"}, host_rvalid, 1);
      check(host_rdata == exp_mem[ea % 2048], {req, " read data"}, host_rdata, exp_mem[ea % 2048]);
    end
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
  end

  initial begin
    int v, seed;
    for (int i = 0; i < 2048; i++) begin mem[i] = '0; exp_mem[i] = '0; end
    seed = $urandom(1234);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset values
    rd_reg(1, v); check(v == 0, "R1 host ptr", v, 0);
    rd_reg(2, v); check(v == 'hFF, "R1 stop ptr", v, 'hFF);
    rd_reg(3, v); check(v == 0, "R1 disk ptr", v, 0);
    rd_reg(0, v); check(v == 0, "R1 config", v, 0);
    rd_reg(4, v); check(v == 0, "R1 control", v, 0);
    check(!host_req && !host_busy && !host_irq && !ram_en, "R1 outputs", {host_req, host_busy, host_irq, ram_en}, 0);

    // R2 size decode: pointer at size-1 wraps to 0
    for (int c = 0; c < 8; c++) begin
      wr_reg(0, c);
      wr_reg(1, size_of(c) - 1);
      wr_reg(2, 0);
      wr_reg(4, 1);
      host_word(0, '0, size_of(c) - 1, "R2");
      rd_reg(1, v); check(v == 0, "R2 wrap of host ptr", v, 0);
      wr_reg(4, 0);
    end

    // R3 R4 R5 burst across the wrap, host to buffer
    wr_reg(0, 7);
    wr_reg(1, 'h1FE);
    wr_reg(2, 'h001);
    wr_reg(4, 5);
    rd_reg(4, v); check(v == 5, "R5 start clears done", v, 5);
    for (int k = 0; k < 4; k++) begin
      check(host_req, "R5 request during burst", host_req, 1);
      host_word(1, 16'hA0 + 16'(k), ('h1FE + k) % 512, "R3");
    end
    rd_reg(4, v); check(v == 6, "R5 done set run cleared", v, 6);
    check(!host_req, "R5 request dropped", host_req, 0);
    host_stb = 1; #1;
    check(!ram_en, "R5 strobe after done ignored", ram_en, 0);
    @(negedge clk); host_stb = 0;
    rd_reg(1, v); check(v == 2, "R4 host ptr after wrap", v, 2);
    // buffer to host read back
    wr_reg(1, 'h1FE);
    wr_reg(4, 1);
    for (int k = 0; k < 4; k++) host_word(0, '0, ('h1FE + k) % 512, "R3");
    rd_reg(4, v); check(v == 2, "R5 done after read burst", v, 2);

    // R6 R7 completion modes
    wr_reg(1, 5); wr_reg(2, 5);
    wr_reg(4, 1);
    host_word(0, '0, 5, "R6");
    rd_reg(4, v); check(v == 2, "R6 no flags without modes", v, 2);
    check(!host_busy && !host_irq, "R7 outputs idle without modes", {host_busy, host_irq}, 0);
    wr_reg(1, 5); wr_reg(4, 'h09);
    host_word(0, '0, 5, "R7");
    check(host_irq && !host_busy, "R7 irq only", {host_busy, host_irq}, 1);
    wr_reg(1, 5); wr_reg(4, 'h19);
    host_word(0, '0, 5, "R6");
    rd_reg(4, v); check(v == 'hDA, "R6 busy and irq flags", v, 'hDA);
    check(host_busy && host_irq, "R6 outputs set", {host_busy, host_irq}, 3);
    wr_reg(4, 'h18);
    check(!host_busy && !host_irq, "R7 flags cleared by write", {host_busy, host_irq}, 0);

    // R8 data port with and without auto increment
    wr_reg(0, 'hE);
    wr_reg(3, 'h3FF);
    wr_reg(5, 'h1111); exp_mem['h3FF] = 16'h1111;
    wr_reg(5, 'h2222); exp_mem[0] = 16'h2222;
    rd_reg(3, v); check(v == 1, "R8 disk ptr auto wrap", v, 1);
    wr_reg(3, 'h3FF);
    rd_reg(5, v); check(v == 'h1111, "R8 port read", v, 'h1111);
    rd_reg(5, v); check(v == 'h2222, "R8 port read after wrap", v, 'h2222);
    wr_reg(0, 6);
    wr_reg(3, 'h3FF);
    rd_reg(5, v); rd_reg(5, v); check(v == 'h1111, "R8 port read no increment", v, 'h1111);
    rd_reg(3, v); check(v == 'h3FF, "R8 disk ptr holds", v, 'h3FF);

    // R9 arbitration
    wr_reg(1, 'h10); wr_reg(2, 'h10); wr_reg(3, 'h20);
    wr_reg(4, 5);
    host_stb = 1; host_wdata = 16'hBEEF;
    cpu_sel = 1; cpu_wr = 1; cpu_addr = 3'd5; cpu_wdata = 16'hCAFE;
    #1;
    check(!cpu_ready, "R9 processor stalled", cpu_ready, 0);
    check(ram_addr == AW'('h10) && ram_we, "R9 host owns RAM", ram_addr, 'h10);
    @(negedge clk); host_stb = 0; #1;
    check(cpu_ready, "R9 processor proceeds", cpu_ready, 1);
    check(ram_en && ram_addr == AW'('h20), "R9 processor address", ram_addr, 'h20);
    @(negedge clk); cpu_sel = 0; cpu_wr = 0;
    exp_mem['h10] = 16'hBEEF; exp_mem['h20] = 16'hCAFE;
    rd_reg(5, v); check(v == 'hCAFE, "R9 processor word stored", v, 'hCAFE);
    wr_reg(1, 'h10); wr_reg(4, 1);
    host_word(0, '0, 'h10, "R9");

    // R10 RAM off
    wr_reg(0, 'hE);
    wr_reg(3, 'h30); wr_reg(1, 'h40); wr_reg(2, 'h40);
    wr_reg(4, 'h25);
    check(!host_req, "R10 request low", host_req, 0);
    host_stb = 1; #1;
    check(!ram_en, "R10 host strobe ignored", ram_en, 0);
    @(negedge clk); host_stb = 0;
    cpu_sel = 1; cpu_wr = 1; cpu_addr = 3'd5; cpu_wdata = 16'h5555; #1;
    check(!ram_en && cpu_ready, "R10 port write no RAM", ram_en, 0);
    @(negedge clk); cpu_sel = 0; cpu_wr = 0;
    rd_reg(5, v); check(v == 0, "R10 port read returns zero", v, 0);
    rd_reg(3, v); check(v == 'h30, "R10 disk ptr holds", v, 'h30);
    rd_reg(4, v); check(v == 'h25, "R10 control unchanged", v, 'h25);
    wr_reg(4, 0);
    rd_reg(5, v); check(v == int'(exp_mem['h30]), "R10 write dropped", v, exp_mem['h30]);
    rd_reg(1, v); check(v == 'h40, "R10 host ptr holds", v, 'h40);

    // random bursts R3 R4 R5
    for (int it = 0; it < 40; it++) begin
      int code, sz, h, n, st;
      bit d;
      code = 5 + int'($urandom % 3);
      sz = size_of(code);
      h = int'($urandom % sz);
      n = 1 + int'($urandom % 40);
      st = (h + n - 1) % sz;
      d = 1'($urandom % 2);
      wr_reg(0, code); wr_reg(1, h); wr_reg(2, st);
      wr_reg(4, d ? 5 : 1);
      for (int k = 0; k < n; k++) host_word(d, 16'($urandom), (h + k) % sz, "R3");
      rd_reg(4, v); check(v[1:0] == 2'b10, "R5 random burst end", v, d ? 6 : 2);
      check(!host_req, "R5 random request low", host_req, 0);
    end

    summary();
  end
endmodule